// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Bank

This block gives a host a byte-wide window into 256 configuration registers through two I/O addresses: one address holds a pointer that selects a register, the other reads or writes the register it points at. Each register applies its own write mask, so reserved bits always read back as zero. Reads have no side effects and are answered combinationally from the addressed port.

A handful of registers are decoded into registered control outputs for neighbouring logic: read and write enables for thirteen shadow-memory segments of the upper BIOS area (twelve 16 KB segments from 0xC0000 to 0xEFFFF, then a single 64 KB region at 0xF0000), an SMRAM enable, four PCI interrupt routing lines with valid flags, and a base address and IRQ selection for two UARTs that resolves address collisions on its own.

Top module: `chipset_cfg_bank`

## Requirements
- R1: A write to I/O address 0x22 loads the 8-bit pointer; a read of 0x22 returns the pointer. A write to any address other than 0x22 and 0x23 changes nothing, and a read of such an address returns 0xFF.
- R2: A write to address 0x23 stores the written byte ANDed with the selected register's mask; a read of 0x23 returns the stored byte. Masks: 0x21→0xFE, 0x22→0x7F, 0x28→0xE3, 0x29→0x0F, 0x36→0x3F, 0x52..0x55→0x8F, 0x59→0xF1, all others 0xFF.
- R3: A read of 0x23 while the pointer is 0xC0 or above returns 0xFF regardless of the stored value.
- R4: After reset every register reads 0x00 except register 0x7B, which reads 0xFF, and the pointer reads 0x00.
- R5: Registers 0x25, 0x26, 0x27 control shadow segments 0..11 (segment s covers 0xC0000 + s·16 KB); segment 4r+k is governed by register 0x25+r, bit 2k giving its write enable and bit 2k+1 its read enable.
- R6: Register 0x28 bit 0 is the write enable and bit 1 the read enable of shadow output bit 12 (the 64 KB region at 0xF0000).
- R7: The SMRAM enable output equals bit 7 of register 0x28.
- R8: Registers 0x52, 0x53, 0x54, 0x55 drive routing lines 0..3 (INTA..INTD). Line j's valid flag is bit 7 of its register; its 4-bit IRQ field (bits 4j+3:4j of the IRQ output) is bits 3:0 of the register when valid and 0 otherwise.
- R9: Register 0x59 places both UARTs at 0x3F8 by default; bit 6 clears UART0 address bit 8, bit 7 clears UART0 address bit 4, bit 4 clears UART1 address bit 8, bit 5 clears UART1 address bit 4.
- R10: When the two UART addresses from R9 are equal, UART0 is placed at 0x3F8 and UART1 at 0x2F8.
- R11: When UART0's final address has bit 8 clear, UART0 gets IRQ 3 and UART1 IRQ 4; otherwise UART0 gets IRQ 4 and UART1 IRQ 3.
- R12: Decoded outputs change at the second rising edge after the edge that accepts the data write (one edge to store, one to decode), and hold the decode of the reset register image from reset onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr_en | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | AW (16) | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data for the address on io_addr |
| shadow_wr_en | output | 13 | Per-segment shadow write enables, bit 12 = 0xF0000 region |
| shadow_rd_en | output | 13 | Per-segment shadow read enables, bit 12 = 0xF0000 region |
| smram_en | output | 1 | SMRAM enable |
| pirq_valid | output | 4 | Routing enabled for INTA..INTD |
| pirq_irq | output | 16 | IRQ number per line, 4 bits each |
| uart0_base | output | 16 | UART0 I/O base address |
| uart1_base | output | 16 | UART1 I/O base address |
| uart0_irq | output | 4 | UART0 IRQ number |
| uart1_irq | output | 4 | UART1 IRQ number |

## Verification
Every cycle the assertions check that the pointer takes the written byte, that high-pointer and unmapped reads give 0xFF, that SMRAM follows bit 7 of a write to register 0x28 two edges later, that a disabled routing line carries a zero IRQ field, and that the UART pair never shares an address or an IRQ and that the IRQ choice agrees with UART0's address bit 8. The masks of each register, the reset image, the exact segment-to-bit mapping and the arithmetic of the UART addresses under all sixteen select combinations are only visible in the bench's sweeps, which write every register with all-ones and all-zeros and walk each decoded register through every byte value.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int DW      = 8;
    localparam int IRQ_W   = 4;
    localparam int UART_AW = 16;

    localparam logic [7:0] REG_SHADOW0   = 8'h25;
    localparam logic [7:0] REG_SHADOW_TOP = 8'h28;
    localparam logic [7:0] REG_PIRQ0     = 8'h52;
    localparam logic [7:0] REG_UART_SEL  = 8'h59;
    localparam logic [7:0] REG_PRESET_FF = 8'h7B;
    localparam logic [7:0] READ_CUTOFF   = 8'hC0;
    localparam int         SMRAM_BIT     = 7;

    localparam logic [UART_AW-1:0] UART_PRIMARY   = 16'h03F8;
    localparam logic [UART_AW-1:0] UART_SECONDARY = 16'h02F8;

    typedef struct packed {
        logic [UART_AW-1:0] base0;
        logic [UART_AW-1:0] base1;
        logic [IRQ_W-1:0]   irq0;
        logic [IRQ_W-1:0]   irq1;
    } uart_map_t;

    function automatic logic [DW-1:0] wr_mask(input logic [7:0] idx);
        case (idx)
            8'h21:                    return 8'hFE;
            8'h22:                    return 8'h7F;
            8'h28:                    return 8'hE3;
            8'h29:                    return 8'h0F;
            8'h36:                    return 8'h3F;
            8'h52, 8'h53, 8'h54, 8'h55: return 8'h8F;
            8'h59:                    return 8'hF1;
            default:                  return 8'hFF;
        endcase
    endfunction

    // sel = bits 7:4 of the UART select register
    function automatic uart_map_t uart_decode(input logic [3:0] sel);
        uart_map_t m;
        m.base0 = UART_PRIMARY;
        m.base1 = UART_PRIMARY;
        if (sel[0]) m.base1[8] = 1'b0;
        if (sel[1]) m.base1[4] = 1'b0;
        if (sel[2]) m.base0[8] = 1'b0;
        if (sel[3]) m.base0[4] = 1'b0;
        if (m.base0 == m.base1) begin
            m.base0 = UART_PRIMARY;
            m.base1 = UART_SECONDARY;
        end
        if (m.base0[8]) begin
            m.irq0 = 4'd4;
            m.irq1 = 4'd3;
        end else begin
            m.irq0 = 4'd3;
            m.irq1 = 4'd4;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfgbank_regfile.sv
module cfgbank_regfile
    import cfgbank_pkg::*;
#(
    parameter int                AW           = 16,
    parameter logic [AW-1:0]     IDX_PORT     = 16'h0022,
    parameter logic [AW-1:0]     DATA_PORT    = 16'h0023,
    parameter int                SEG_REGS     = 3,
    parameter int                NUM_INTX     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_wr_en,
    input  logic [AW-1:0]                 io_addr,
    input  logic [DW-1:0]                 io_wdata,
    output logic [DW-1:0]                 io_rdata,
    output logic [7:0]                    idx_q,
    output logic [SEG_REGS-1:0][DW-1:0]   seg_regs,
    output logic [DW-1:0]                 top_reg,
    output logic [NUM_INTX-1:0][DW-1:0]   pirq_regs,
    output logic [DW-1:0]                 uart_reg
);

    localparam int NUM_REGS = 256;

    typedef struct packed {
        logic [7:0]                   idx;
        logic [NUM_REGS-1:0][DW-1:0]  regs;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (io_wr_en && io_addr == IDX_PORT) begin
            rf_d.idx = io_wdata;
        end else if (io_wr_en && io_addr == DATA_PORT) begin
            rf_d.regs[rf_q.idx] = io_wdata & wr_mask(rf_q.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q.idx                 <= '0;
            rf_q.regs                <= '0;
            rf_q.regs[REG_PRESET_FF] <= 8'hFF;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        if (io_addr == IDX_PORT)
            io_rdata = rf_q.idx;
        else if (io_addr == DATA_PORT)
            io_rdata = (rf_q.idx >= READ_CUTOFF) ? 8'hFF : rf_q.regs[rf_q.idx];
        else
            io_rdata = 8'hFF;
    end

    assign idx_q    = rf_q.idx;
    assign top_reg  = rf_q.regs[REG_SHADOW_TOP];
    assign uart_reg = rf_q.regs[REG_UART_SEL];

    for (genvar r = 0; r < SEG_REGS; r++) begin : g_seg
        assign seg_regs[r] = rf_q.regs[REG_SHADOW0 + r];
    end

    for (genvar j = 0; j < NUM_INTX; j++) begin : g_pirq
        assign pirq_regs[j] = rf_q.regs[REG_PIRQ0 + j];
    end

endmodule

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
#(
    parameter int SEG_REGS     = 3,
    parameter int SEGS_PER_REG = 4,
    parameter int NUM_INTX     = 4,
    localparam int NSEG        = SEG_REGS * SEGS_PER_REG,
    localparam int NSHADOW     = NSEG + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEG_REGS-1:0][DW-1:0]   seg_regs,
    input  logic [DW-1:0]                 top_reg,
    input  logic [NUM_INTX-1:0][DW-1:0]   pirq_regs,
    input  logic [DW-1:0]                 uart_reg,
    output logic [NSHADOW-1:0]            shadow_wr_en,
    output logic [NSHADOW-1:0]            shadow_rd_en,
    output logic                          smram_en,
    output logic [NUM_INTX-1:0]           pirq_valid,
    output logic [NUM_INTX*IRQ_W-1:0]     pirq_irq,
    output logic [UART_AW-1:0]            uart0_base,
    output logic [UART_AW-1:0]            uart1_base,
    output logic [IRQ_W-1:0]              uart0_irq,
    output logic [IRQ_W-1:0]              uart1_irq
);

    typedef struct packed {
        logic [NSHADOW-1:0]        wr;
        logic [NSHADOW-1:0]        rd;
        logic                      smram;
        logic [NUM_INTX-1:0]       vld;
        logic [NUM_INTX*IRQ_W-1:0] irq;
        uart_map_t                 uart;
    } dec_t;

    dec_t dec_d, dec_q;

    logic unused_bits;
    assign unused_bits = ^{top_reg[6:2], uart_reg[3:0], pirq_regs};

    always_comb begin
        dec_d = '0;
        for (int r = 0; r < SEG_REGS; r++) begin
            for (int k = 0; k < SEGS_PER_REG; k++) begin
                dec_d.wr[r*SEGS_PER_REG + k] = seg_regs[r][2*k];
                dec_d.rd[r*SEGS_PER_REG + k] = seg_regs[r][2*k + 1];
            end
        end
        dec_d.wr[NSEG] = top_reg[0];
        dec_d.rd[NSEG] = top_reg[1];
        dec_d.smram    = top_reg[SMRAM_BIT];
        for (int j = 0; j < NUM_INTX; j++) begin
            dec_d.vld[j] = pirq_regs[j][7];
            dec_d.irq[j*IRQ_W +: IRQ_W] = pirq_regs[j][7] ? pirq_regs[j][IRQ_W-1:0] : '0;
        end
        dec_d.uart = uart_decode(uart_reg[7:4]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= '0;
            dec_q.uart <= uart_decode(4'h0);
        end else begin
            dec_q <= dec_d;
        end
    end

    assign shadow_wr_en = dec_q.wr;
    assign shadow_rd_en = dec_q.rd;
    assign smram_en     = dec_q.smram;
    assign pirq_valid   = dec_q.vld;
    assign pirq_irq     = dec_q.irq;
    assign uart0_base   = dec_q.uart.base0;
    assign uart1_base   = dec_q.uart.base1;
    assign uart0_irq    = dec_q.uart.irq0;
    assign uart1_irq    = dec_q.uart.irq1;

endmodule

// File: rtl/chipset_cfg_bank.sv
module chipset_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int            AW           = 16,
    parameter logic [AW-1:0] IDX_PORT     = 16'h0022,
    parameter logic [AW-1:0] DATA_PORT    = 16'h0023,
    parameter int            SEG_REGS     = 3,
    parameter int            SEGS_PER_REG = 4,
    parameter int            NUM_INTX     = 4,
    localparam int           NSHADOW      = SEG_REGS * SEGS_PER_REG + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr_en,
    input  logic [AW-1:0]             io_addr,
    input  logic [DW-1:0]             io_wdata,
    output logic [DW-1:0]             io_rdata,
    output logic [NSHADOW-1:0]        shadow_wr_en,
    output logic [NSHADOW-1:0]        shadow_rd_en,
    output logic                      smram_en,
    output logic [NUM_INTX-1:0]       pirq_valid,
    output logic [NUM_INTX*IRQ_W-1:0] pirq_irq,
    output logic [UART_AW-1:0]        uart0_base,
    output logic [UART_AW-1:0]        uart1_base,
    output logic [IRQ_W-1:0]          uart0_irq,
    output logic [IRQ_W-1:0]          uart1_irq
);

    logic [7:0]                  idx_q;
    logic [SEG_REGS-1:0][DW-1:0] seg_regs;
    logic [DW-1:0]               top_reg;
    logic [NUM_INTX-1:0][DW-1:0] pirq_regs;
    logic [DW-1:0]               uart_reg;

    cfgbank_regfile #(
        .AW(AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT),
        .SEG_REGS(SEG_REGS), .NUM_INTX(NUM_INTX)
    ) u_regfile (
        .clk(clk), .rst_n(rst_n),
        .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .idx_q(idx_q),
        .seg_regs(seg_regs), .top_reg(top_reg),
        .pirq_regs(pirq_regs), .uart_reg(uart_reg)
    );

    cfgbank_decode #(
        .SEG_REGS(SEG_REGS), .SEGS_PER_REG(SEGS_PER_REG), .NUM_INTX(NUM_INTX)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .seg_regs(seg_regs), .top_reg(top_reg),
        .pirq_regs(pirq_regs), .uart_reg(uart_reg),
        .shadow_wr_en(shadow_wr_en), .shadow_rd_en(shadow_rd_en),
        .smram_en(smram_en), .pirq_valid(pirq_valid), .pirq_irq(pirq_irq),
        .uart0_base(uart0_base), .uart1_base(uart1_base),
        .uart0_irq(uart0_irq), .uart1_irq(uart1_irq)
    );

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
#(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] IDX_PORT  = 16'h0022,
    parameter logic [AW-1:0] DATA_PORT = 16'h0023,
    parameter int            NUM_INTX  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      io_wr_en,
    input logic [AW-1:0]             io_addr,
    input logic [DW-1:0]             io_wdata,
    input logic [DW-1:0]             io_rdata,
    input logic [7:0]                idx_q,
    input logic                      smram_en,
    input logic [NUM_INTX-1:0]       pirq_valid,
    input logic [NUM_INTX*IRQ_W-1:0] pirq_irq,
    input logic [UART_AW-1:0]        uart0_base,
    input logic [UART_AW-1:0]        uart1_base,
    input logic [IRQ_W-1:0]          uart0_irq,
    input logic [IRQ_W-1:0]          uart1_irq
);

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == IDX_PORT) |=> (idx_q == $past(io_wdata))); // R1

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != IDX_PORT && io_addr != DATA_PORT) |-> (io_rdata == 8'hFF)); // R1

    AST_HIGH_INDEX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == DATA_PORT && idx_q >= READ_CUTOFF) |-> (io_rdata == 8'hFF)); // R3

    AST_SMRAM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == DATA_PORT && idx_q == REG_SHADOW_TOP)
        |=> ##1 (smram_en == $past(io_wdata[SMRAM_BIT], 2))); // R7

    for (genvar j = 0; j < NUM_INTX; j++) begin : g_quiet
        AST_PIRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !pirq_valid[j] |-> (pirq_irq[j*IRQ_W +: IRQ_W] == '0)); // R8
    end

    AST_UART_APART: assert property (@(posedge clk) disable iff (!rst_n)
        uart0_base != uart1_base); // R10

    AST_UART_IRQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (uart0_irq == 4'd3 && uart1_irq == 4'd4) ||
        (uart0_irq == 4'd4 && uart1_irq == 4'd3)); // R11

    AST_UART_IRQ_BIT8: assert property (@(posedge clk) disable iff (!rst_n)
        uart0_base[8] |-> (uart0_irq == 4'd4)); // R11

endmodule

bind chipset_cfg_bank cfgbank_chk #(
    .AW(AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .NUM_INTX(NUM_INTX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .idx_q(idx_q),
    .smram_en(smram_en), .pirq_valid(pirq_valid), .pirq_irq(pirq_irq),
    .uart0_base(uart0_base), .uart1_base(uart1_base),
    .uart0_irq(uart0_irq), .uart1_irq(uart1_irq)
);

// File: tb/chipset_cfg_bank_tb.sv
`timescale 1ns/1ps
module chipset_cfg_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr_en;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [12:0] shadow_wr_en, shadow_rd_en;
    logic        smram_en;
    logic [3:0]  pirq_valid;
    logic [15:0] pirq_irq;
    logic [15:0] uart0_base, uart1_base;
    logic [3:0]  uart0_irq, uart1_irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    localparam logic [15:0] IDLE_ADDR = 16'h0080;

    always #4 clk = ~clk;

    chipset_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .shadow_wr_en(shadow_wr_en), .shadow_rd_en(shadow_rd_en),
        .smram_en(smram_en), .pirq_valid(pirq_valid), .pirq_irq(pirq_irq),
        .uart0_base(uart0_base), .uart1_base(uart1_base),
        .uart0_irq(uart0_irq), .uart1_irq(uart1_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0; io_addr = IDLE_ADDR; io_wdata = 8'h00;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a;
        #1 d = io_rdata;
        io_addr = IDLE_ADDR;
    endtask

    task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
        io_write(16'h0022, i);
        io_write(16'h0023, v);
    endtask

    function automatic logic [7:0] mask_of(input int i);
        if (i == 'h21) return 8'hFE;
        if (i == 'h22) return 8'h7F;
        if (i == 'h28) return 8'hE3;
        if (i == 'h29) return 8'h0F;
        if (i == 'h36) return 8'h3F;
        if (i >= 'h52 && i <= 'h55) return 8'h8F;
        if (i == 'h59) return 8'hF1;
        return 8'hFF;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] sh [4];
        logic [7:0] pq [4];

        rst_n = 1'b0; io_wr_en = 1'b0; io_addr = IDLE_ADDR; io_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R12: decoded outputs reflect the reset image
        check("R5", "reset shadow_wr", shadow_wr_en, 0);
        check("R5", "reset shadow_rd", shadow_rd_en, 0);
        check("R7", "reset smram", smram_en, 0);
        check("R8", "reset valid", pirq_valid, 0);
        check("R8", "reset irq", pirq_irq, 0);
        check("R10", "reset uart0 base", uart0_base, 16'h03F8);
        check("R10", "reset uart1 base", uart1_base, 16'h02F8);
        check("R11", "reset uart0 irq", uart0_irq, 4);
        check("R11", "reset uart1 irq", uart1_irq, 3);
        io_read(16'h0022, rd);
        check("R4", "reset pointer", rd, 0);

        // R4 / R3: reset image readback over every index
        for (int i = 0; i < 256; i++) begin
            io_write(16'h0022, 8'(i));
            io_read(16'h0023, rd);
            if (i >= 'hC0)      check("R3", $sformatf("reset read %0h", i), rd, 8'hFF);
            else if (i == 'h7B) check("R4", "reset read 7B", rd, 8'hFF);
            else                check("R4", $sformatf("reset read %0h", i), rd, 8'h00);
        end

        // R1: pointer readback, unmapped addresses
        io_write(16'h0022, 8'h80);
        io_read(16'h0022, rd);
        check("R1", "pointer readback", rd, 8'h80);
        io_write(16'h0024, 8'h5A);
        io_write(16'h0122, 8'h33);
        io_read(16'h0022, rd);
        check("R1", "pointer after unmapped write", rd, 8'h80);
        io_read(16'h0023, rd);
        check("R1", "reg 80 after unmapped write", rd, 8'h00);
        io_read(16'h0024, rd);
        check("R1", "unmapped read", rd, 8'hFF);

        // R2 / R3: all-ones then all-zeros through every register
        for (int i = 0; i < 256; i++) begin
            set_reg(8'(i), 8'hFF);
            io_read(16'h0023, rd);
            check(i >= 'hC0 ? "R3" : "R2", $sformatf("ones read %0h", i), rd,
                  i >= 'hC0 ? 8'hFF : mask_of(i));
            set_reg(8'(i), 8'h00);
            io_read(16'h0023, rd);
            check(i >= 'hC0 ? "R3" : "R2", $sformatf("zeros read %0h", i), rd,
                  i >= 'hC0 ? 8'hFF : 8'h00);
        end
        @(negedge clk);

        // R12: decode lags the store by one edge
        set_reg(8'h26, 8'h0C);
        check("R12", "shadow_wr before decode edge", shadow_wr_en, 0);
        @(negedge clk);
        check("R12", "shadow_wr after decode edge", shadow_wr_en, 13'h0020);
        check("R12", "shadow_rd after decode edge", shadow_rd_en, 13'h0020);
        set_reg(8'h26, 8'h00);
        @(negedge clk);

        // R5 / R6 / R7: shadow sweep
        for (int r = 0; r < 4; r++) sh[r] = 8'h00;
        for (int r = 0; r < 4; r++) begin
            io_write(16'h0022, 8'(8'h25 + r));
            for (int p = 0; p < 256; p++) begin
                logic [12:0] ew, er;
                io_write(16'h0023, 8'(p));
                sh[r] = (r == 3) ? (8'(p) & 8'hE3) : 8'(p);
                @(negedge clk);
                for (int s = 0; s < 12; s++) begin
                    ew[s] = sh[s / 4][2 * (s % 4)];
                    er[s] = sh[s / 4][2 * (s % 4) + 1];
                end
                ew[12] = sh[3][0];
                er[12] = sh[3][1];
                check(r == 3 ? "R6" : "R5", $sformatf("shadow_wr r%0d p%0h", r, p), shadow_wr_en, ew);
                check(r == 3 ? "R6" : "R5", $sformatf("shadow_rd r%0d p%0h", r, p), shadow_rd_en, er);
                if (r == 3) check("R7", $sformatf("smram p%0h", p), smram_en, sh[3][7]);
            end
            io_write(16'h0023, 8'h00);
            sh[r] = 8'h00;
        end

        // R8: routing sweep
        for (int j = 0; j < 4; j++) pq[j] = 8'h00;
        for (int j = 0; j < 4; j++) begin
            io_write(16'h0022, 8'(8'h52 + j));
            for (int p = 0; p < 256; p++) begin
                io_write(16'h0023, 8'(p));
                pq[j] = 8'(p);
                @(negedge clk);
                for (int q = 0; q < 4; q++) begin
                    check("R8", $sformatf("valid line%0d p%0h", q, p), pirq_valid[q], pq[q][7]);
                    check("R8", $sformatf("irq line%0d p%0h", q, p), pirq_irq[4*q +: 4],
                          pq[q][7] ? 4'(pq[q][3:0]) : 4'h0);
                end
            end
            io_write(16'h0023, 8'h00);
            pq[j] = 8'h00;
        end

        // R9 / R10 / R11: UART select sweep
        io_write(16'h0022, 8'h59);
        for (int p = 0; p < 256; p++) begin
            logic [15:0] b0, b1;
            logic [3:0]  i0, i1;
            io_write(16'h0023, 8'(p));
            @(negedge clk);
            b0 = 16'h03F8 - (p[6] ? 16'h0100 : 16'h0) - (p[7] ? 16'h0010 : 16'h0);
            b1 = 16'h03F8 - (p[4] ? 16'h0100 : 16'h0) - (p[5] ? 16'h0010 : 16'h0);
            if (b0 == b1) begin
                b0 = 16'h03F8; b1 = 16'h02F8;
            end
            i0 = b0[8] ? 4'd4 : 4'd3;
            i1 = b0[8] ? 4'd3 : 4'd4;
            check((p[7:4] == 4'h0 || p[7:4] == 4'h5 || p[7:4] == 4'hA || p[7:4] == 4'hF) ? "R10" : "R9",
                  $sformatf("uart0 base p%0h", p), uart0_base, b0);
            check("R9", $sformatf("uart1 base p%0h", p), uart1_base, b1);
            check("R11", $sformatf("uart0 irq p%0h", p), uart0_irq, i0);
            check("R11", $sformatf("uart1 irq p%0h", p), uart1_irq, i1);
            io_read(16'h0023, rd);
            check("R2", $sformatf("uart reg read p%0h", p), rd, 8'(p) & 8'hF1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule